// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is the serial core of an SPI master. It sends one word of 8 to 32 bits per transaction on MOSI and collects the same number of bits from MISO. The host chooses the word length, the bit order, the SCLK idle level, and the SCLK edge type used to drive MOSI and to sample MISO. The two edge selects are independent of each other. The SCLK rate is set outside the block by a `tick` strobe, and each tick marks one SCLK half-period.

A `start` strobe begins a transfer of one or more words. Between two words of a burst, SCLK pauses for a gap of a whole number of SCLK periods plus one half. Each word can have its byte order reversed, both on the wire and in the received word. Slave select is driven either by the engine or directly by the host. At the end of every word the engine pulses `done`, presents the received word and sets a sticky completion flag. That flag can raise an interrupt. The host can cut a transfer short with `abort`.

Top module: `spi_xfer_engine`

## Requirements
- R1: The word length N comes from `len_code`. Codes 8 to 31 give that many bits, code 0 gives 32 bits, and codes 1 to 7 give 8 bits. Each word takes exactly 2N SCLK edges, one edge per `tick` while the word runs.
- R2: While idle, SCLK sits at `cpol` (0 = low, 1 = high). The first edge of a word moves SCLK away from `cpol`, and SCLK is back at `cpol` after the last edge.
- R3: When `lsb_first`=0, bit N-1 of the word goes out first and the first bit received lands in bit N-1. When `lsb_first`=1, bit 0 goes out first and is received first.
- R4: The first bit is on MOSI from the moment the word is loaded. After that, MOSI moves to the next bit only on rising SCLK edges when `tx_neg`=0, or only on falling edges when `tx_neg`=1. The first edge of a word never moves MOSI.
- R5: MISO is captured on rising SCLK edges when `rx_neg`=0 and on falling edges when `rx_neg`=1.
- R6: A burst holds `words_m1`+1 words. From the last edge of one word to the first edge of the next there are 2*`gap_sel`+1 ticks, which is (`gap_sel`+0.5) SCLK periods.
- R7: When `reorder_en`=1 and N is 16, 24 or 32, the bytes of the word are reversed end to end. This applies to the transmitted word and to the received word. For any other N, `reorder_en` has no effect.
- R8: When `auto_ss`=1, `ss_n` is low while a word is being shifted and high when idle and during a nonzero gap. When `auto_ss`=0, `ss_n` is the inverse of `ss_manual` at all times.
- R9: `busy` rises the cycle after `start` and falls in the same cycle as the final `done`. A `start` while busy is ignored. `abort` clears `busy` on the next cycle, returns SCLK to idle and suppresses `done`.
- R10: `done` is a one-cycle pulse in the cycle after the tick of a word's last edge. It sets `flag`. `if_clr` clears `flag`, but a simultaneous set wins. `irq` is high when `flag` and `irq_en` are both high.
- R11: `rx_word` changes only together with `done`. Its bits N and above read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One SCLK half-period has elapsed |
| start | input | 1 | Begin a transfer (ignored while busy) |
| abort | input | 1 | Stop the transfer at once |
| words_m1 | input | WCNT_W | Number of words in the burst minus one |
| len_code | input | 5 | Word length code |
| lsb_first | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| cpol | input | 1 | SCLK idle level |
| tx_neg | input | 1 | MOSI drive edge: 0 rising, 1 falling |
| rx_neg | input | 1 | MISO sample edge: 0 rising, 1 falling |
| gap_sel | input | GAP_W | Inter-word gap in whole SCLK periods (plus one half) |
| reorder_en | input | 1 | Reverse byte order for 16/24/32-bit words |
| auto_ss | input | 1 | Engine drives slave select |
| ss_manual | input | 1 | Host slave select level when `auto_ss`=0 (1 = selected) |
| irq_en | input | 1 | Interrupt enable |
| if_clr | input | 1 | Clear the completion flag |
| tx_word | input | 32 | Word to send, sampled when each word is loaded |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Slave select, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Word completed pulse |
| flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |
| rx_word | output | 32 | Last received word |

## Verification
The bench builds the engine with its default parameters: a 4-bit gap field, a 2-bit word count and 32-bit words. The bench ties MISO back to MOSI. It then sweeps lengths of 8, 12, 16, 24, 31 and 32 bits and a clamped short code, across every polarity and edge pairing where the drive and sample edges differ. A gap setting of 3 lets the bench measure a 7-tick pause exactly. A gap of 0 shows slave select held low across a word boundary. A three-word burst exercises the word count field.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int DATA_W = 32;
  localparam int LEN_W  = $clog2(DATA_W);
  localparam int CNT_W  = $clog2(DATA_W) + 1;
  localparam int EDGE_W = $clog2(2 * DATA_W);
  localparam int MIN_LEN = 8;

  function automatic logic [CNT_W-1:0] decode_len(input logic [LEN_W-1:0] code);
    if (code == '0) return CNT_W'(DATA_W);
    if (int'(code) < MIN_LEN) return CNT_W'(MIN_LEN);
    return CNT_W'(code);
  endfunction

  // reverse the bytes of an n-bit word when enabled and n is 16, 24 or 32
  function automatic logic [DATA_W-1:0] byte_flip(input logic [DATA_W-1:0] w,
                                                  input logic [CNT_W-1:0]  n,
                                                  input logic              en);
    logic [DATA_W-1:0] r;
    int nb;
    nb = int'(n) / 8;
    if (!en || (int'(n) != 16 && int'(n) != 24 && int'(n) != 32)) return w;
    r = '0;
    for (int k = 0; k < DATA_W / 8; k++)
      if (k < nb) r[8*k +: 8] = w[8*(nb-1-k) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/spi_eng_shift.sv
module spi_eng_shift
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              finish,
  input  logic              drv_adv,
  input  logic              smp_en,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [CNT_W-1:0]  nbits,
  input  logic              lsb_first,
  input  logic              reorder_en,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d, rxw_q, rxw_d;
  logic [DATA_W-1:0] rx_cur, aligned, flip_tx;
  logic [CNT_W-1:0]  pad;
  logic              mosi_q, mosi_d;

  always_comb begin
    pad     = CNT_W'(DATA_W) - nbits;
    flip_tx = byte_flip(tx_word, nbits, reorder_en);
    rx_cur  = rx_q;
    if (smp_en)
      rx_cur = lsb_first ? {miso, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], miso};
    aligned = lsb_first ? (rx_cur >> pad) : rx_cur;
    tx_d    = tx_q;
    mosi_d  = mosi_q;
    rx_d    = rx_cur;
    rxw_d   = rxw_q;
    if (finish) rxw_d = byte_flip(aligned, nbits, reorder_en);
    if (load) begin
      tx_d   = lsb_first ? flip_tx : (flip_tx << pad);
      mosi_d = lsb_first ? tx_d[0] : tx_d[DATA_W-1];
      rx_d   = '0;
    end else if (drv_adv) begin
      tx_d   = lsb_first ? (tx_q >> 1) : (tx_q << 1);
      mosi_d = lsb_first ? tx_q[1] : tx_q[DATA_W-2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      rxw_q  <= '0;
      mosi_q <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      rxw_q  <= rxw_d;
      mosi_q <= mosi_d;
    end
  end

  assign mosi    = mosi_q;
  assign rx_word = rxw_q;

  // R11
  rx_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(finish) && $stable(nbits)) |-> ((rxw_q >> nbits) == '0));
  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !drv_adv) |=> $stable(mosi_q));
endmodule

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int GAP_W  = 4,
  parameter int WCNT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              abort,
  input  logic [WCNT_W-1:0] words_m1,
  input  logic [CNT_W-1:0]  nbits,
  input  logic [GAP_W-1:0]  gap_sel,
  input  logic              cpol,
  input  logic              tx_neg,
  input  logic              rx_neg,
  input  logic              auto_ss,
  input  logic              ss_manual,
  input  logic              if_clr,
  input  logic              irq_en,
  output logic              sclk,
  output logic              ss_n,
  output logic              busy,
  output logic              done,
  output logic              flag,
  output logic              irq,
  output logic              load,
  output logic              finish,
  output logic              drv_adv,
  output logic              smp_en
);
  localparam int WAIT_W = GAP_W + 1;

  logic              run_q, run_d, sclk_q, sclk_d, done_q, done_d, flag_q, flag_d;
  logic [EDGE_W-1:0] edge_q, edge_d, last_idx;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [WCNT_W-1:0] left_q, left_d;
  logic              step, rising, is_last, more;

  always_comb begin
    last_idx = EDGE_W'(2 * int'(nbits) - 1);
    step     = run_q & tick & (wait_q == '0);
    rising   = ~sclk_q;
    drv_adv  = step & (rising ^ tx_neg) & (edge_q != '0);
    smp_en   = step & (rising ^ rx_neg);
    is_last  = step & (edge_q == last_idx);
    more     = (left_q != '0);
    load     = ~abort & ((start & ~run_q) | (is_last & more));
    finish   = is_last & ~abort;

    run_d  = run_q;
    sclk_d = sclk_q;
    edge_d = edge_q;
    wait_d = wait_q;
    left_d = left_q;
    if (abort) begin
      run_d  = 1'b0;
      sclk_d = cpol;
    end else if (!run_q) begin
      sclk_d = cpol;
      if (start) begin
        run_d  = 1'b1;
        edge_d = '0;
        wait_d = '0;
        left_d = words_m1;
      end
    end else if (tick) begin
      if (wait_q != '0) begin
        wait_d = wait_q - WAIT_W'(1);
      end else begin
        sclk_d = ~sclk_q;
        if (is_last) begin
          if (more) begin
            edge_d = '0;
            wait_d = {gap_sel, 1'b0};
            left_d = left_q - WCNT_W'(1);
          end else begin
            run_d = 1'b0;
          end
        end else begin
          edge_d = edge_q + EDGE_W'(1);
        end
      end
    end
    done_d = finish;
    flag_d = finish | (flag_q & ~if_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sclk_q <= 1'b0;
      edge_q <= '0;
      wait_q <= '0;
      left_q <= '0;
      done_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      sclk_q <= sclk_d;
      edge_q <= edge_d;
      wait_q <= wait_d;
      left_q <= left_d;
      done_q <= done_d;
      flag_q <= flag_d;
    end
  end

  assign sclk = sclk_q;
  assign busy = run_q;
  assign done = done_q;
  assign flag = flag_q;
  assign irq  = flag_q & irq_en;
  assign ss_n = auto_ss ? ~(run_q & (wait_q == '0)) : ~ss_manual;

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (sclk_q == $past(cpol)));
  // R2
  sclk_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick && !abort) |=> $stable(sclk_q));
  // R10
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> flag_q);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> (done_q || $past(abort)));
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int GAP_W  = 4,
  parameter int WCNT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              abort,
  input  logic [WCNT_W-1:0] words_m1,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              lsb_first,
  input  logic              cpol,
  input  logic              tx_neg,
  input  logic              rx_neg,
  input  logic [GAP_W-1:0]  gap_sel,
  input  logic              reorder_en,
  input  logic              auto_ss,
  input  logic              ss_manual,
  input  logic              irq_en,
  input  logic              if_clr,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              ss_n,
  output logic              busy,
  output logic              done,
  output logic              flag,
  output logic              irq,
  output logic [DATA_W-1:0] rx_word
);
  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic [CNT_W-1:0] nbits;
  logic             load, finish, drv_adv, smp_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];
  assign nbits   = decode_len(len_code);

  spi_eng_ctrl #(.GAP_W(GAP_W), .WCNT_W(WCNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .start(start), .abort(abort),
    .words_m1(words_m1), .nbits(nbits), .gap_sel(gap_sel), .cpol(cpol),
    .tx_neg(tx_neg), .rx_neg(rx_neg), .auto_ss(auto_ss), .ss_manual(ss_manual),
    .if_clr(if_clr), .irq_en(irq_en), .sclk(sclk), .ss_n(ss_n), .busy(busy),
    .done(done), .flag(flag), .irq(irq), .load(load), .finish(finish),
    .drv_adv(drv_adv), .smp_en(smp_en)
  );

  spi_eng_shift u_shift (
    .clk(clk), .rst_n(rst_i_n), .load(load), .finish(finish), .drv_adv(drv_adv),
    .smp_en(smp_en), .tx_word(tx_word), .nbits(nbits), .lsb_first(lsb_first),
    .reorder_en(reorder_en), .miso(miso), .mosi(mosi), .rx_word(rx_word)
  );
endmodule

// File: tb/test_spi_xfer_engine.sv
module test_spi_xfer_engine;
  localparam int TDIV = 4;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0, abort = 1'b0;
  logic [1:0]  words_m1 = '0;
  logic [4:0]  len_code = 5'd8;
  logic        lsb_first = 0, cpol = 0, tx_neg = 1, rx_neg = 0, reorder_en = 0;
  logic [3:0]  gap_sel = 4'd3;
  logic        auto_ss = 1, ss_manual = 0, irq_en = 0, if_clr = 0;
  logic [31:0] tx_word = '0;
  logic        miso, sclk, mosi, ss_n, busy, done, flag, irq;
  logic [31:0] rx_word;

  assign miso = mosi;

  spi_xfer_engine i_spi_xfer_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .abort(abort),
    .words_m1(words_m1), .len_code(len_code), .lsb_first(lsb_first), .cpol(cpol),
    .tx_neg(tx_neg), .rx_neg(rx_neg), .gap_sel(gap_sel), .reorder_en(reorder_en),
    .auto_ss(auto_ss), .ss_manual(ss_manual), .irq_en(irq_en), .if_clr(if_clr),
    .tx_word(tx_word), .miso(miso), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
    .busy(busy), .done(done), .flag(flag), .irq(irq), .rx_word(rx_word)
  );

  always #5 clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    tick = (tdiv == 0);
  end

  int cyc = 0;
  always @(posedge clk) cyc++;

  int total = 0, bad = 0;
  int n_edges, n_dones, n_bits, ss_lo, ss_hi;
  int edge_t[256];
  logic sbits[256];
  logic [31:0] rx_cap;
  logic first_new, busy_at_done;

  // {len, lsb, cpol, tx_neg, rx_neg, reorder, data}
  localparam logic [41:0] VEC [8] = '{
    {5'd8,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFFFFA5},
    {5'd16, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000C3E1},
    {5'd0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h12345678},
    {5'd24, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h55C3B2A1},
    {5'd12, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h00000ABC},
    {5'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h000001FF},
    {5'd16, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000BEEF},
    {5'd31, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'hDEADBEEF}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int len_of(input logic [4:0] c);
    if (c == 0) return 32;
    if (c < 8) return 8;
    return int'(c);
  endfunction

  function automatic logic [31:0] mask_of(input int n);
    logic [63:0] m;
    m = (64'd1 << n) - 64'd1;
    return m[31:0];
  endfunction

  function automatic logic [31:0] flip_model(input logic [31:0] w, input int n, input logic en);
    logic [31:0] r;
    if (!en || !(n == 16 || n == 24 || n == 32)) return w;
    r = '0;
    for (int b = 0; b < n / 8; b++) r[8*b +: 8] = w[8*(n/8-1-b) +: 8];
    return r;
  endfunction

  task automatic run_xfer(input int restart_at);
    logic prev;
    int k;
    n_edges = 0; n_dones = 0; n_bits = 0; ss_lo = 0; ss_hi = 0;
    busy_at_done = 1'b1; rx_cap = '0; first_new = 1'bx;
    @(negedge clk);
    prev = sclk;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (1) begin
      k++;
      start = (k == restart_at);
      if (sclk !== prev) begin
        if (n_edges < 256) edge_t[n_edges] = cyc;
        if (n_edges == 0) first_new = sclk;
        n_edges++;
        if (((sclk && !rx_neg) || (!sclk && rx_neg)) && n_bits < 256) begin
          sbits[n_bits] = mosi;
          n_bits++;
        end
        prev = sclk;
      end
      if (busy) begin
        if (ss_n) ss_hi++; else ss_lo++;
      end
      if (done) begin
        n_dones++;
        rx_cap = rx_word;
        busy_at_done = busy;
      end
      if (!busy) break;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  function automatic int stream_errs(input logic [31:0] w, input int n, input logic lsb, input int words);
    int e;
    e = 0;
    for (int j = 0; j < words; j++)
      for (int i = 0; i < n; i++)
        if (sbits[j*n + i] !== (lsb ? w[i] : w[n-1-i])) e++;
    return e;
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
    finish_run();
  end

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0, "R9 reset busy", 32'(busy), 0);
    chk(done == 0, "R10 reset done", 32'(done), 0);
    chk(flag == 0, "R10 reset flag", 32'(flag), 0);
    chk(sclk == 0, "R2 reset sclk idle", 32'(sclk), 0);
    chk(ss_n == 1, "R8 reset ss_n", 32'(ss_n), 1);
    chk(rx_word == 0, "R11 reset rx_word", rx_word, 0);

    // table of single-word transfers
    for (int v = 0; v < 8; v++) begin
      logic [41:0] e;
      int n;
      logic [31:0] w;
      e = VEC[v];
      @(negedge clk);
      len_code = e[41:37]; lsb_first = e[36]; cpol = e[35]; tx_neg = e[34];
      rx_neg = e[33]; reorder_en = e[32]; tx_word = e[31:0]; words_m1 = '0; auto_ss = 1;
      repeat (2) @(negedge clk);
      n = len_of(e[41:37]);
      w = flip_model(e[31:0] & mask_of(n), n, e[32]);
      run_xfer(-1);
      chk(n_edges == 2*n, "R1 edge count", 32'(n_edges), 32'(2*n));
      chk(n_bits == n, "R1 sampled bit count", 32'(n_bits), 32'(n));
      chk(first_new == !e[35], "R2 first edge direction", 32'(first_new), 32'(!e[35]));
      chk(sclk == e[35], "R2 sclk back to idle", 32'(sclk), 32'(e[35]));
      chk(stream_errs(w, n, e[36], 1) == 0, "R3 R4 R5 R7 serial stream",
          32'(stream_errs(w, n, e[36], 1)), 0);
      chk(rx_cap == (e[31:0] & mask_of(n)), "R11 R7 received word", rx_cap, e[31:0] & mask_of(n));
      chk(n_dones == 1, "R10 one done per word", 32'(n_dones), 1);
      chk(ss_lo > 0 && ss_hi == 0, "R8 auto ss low during word", 32'(ss_hi), 0);
      chk(busy_at_done == 0, "R9 busy falls with done", 32'(busy_at_done), 0);
    end

    // R10 flag and irq
    chk(flag == 1, "R10 flag set", 32'(flag), 1);
    chk(irq == 0, "R10 irq masked", 32'(irq), 0);
    irq_en = 1;
    @(negedge clk);
    chk(irq == 1, "R10 irq enabled", 32'(irq), 1);
    if_clr = 1;
    @(negedge clk);
    if_clr = 0;
    chk(flag == 0 && irq == 0, "R10 flag cleared", 32'(flag), 0);

    // R6 burst with gap 3
    len_code = 5'd8; lsb_first = 0; cpol = 0; tx_neg = 1; rx_neg = 0; reorder_en = 0;
    tx_word = 32'h0000003C; words_m1 = 2'd2; gap_sel = 4'd3;
    repeat (2) @(negedge clk);
    run_xfer(-1);
    chk(n_dones == 3, "R6 burst word count", 32'(n_dones), 3);
    chk(n_edges == 48, "R6 burst edges", 32'(n_edges), 48);
    chk(edge_t[15] - edge_t[14] == TDIV, "R1 in-word edge spacing", 32'(edge_t[15] - edge_t[14]), TDIV);
    chk(edge_t[16] - edge_t[15] == 7*TDIV, "R6 gap of 3.5 periods", 32'(edge_t[16] - edge_t[15]), 7*TDIV);
    chk(edge_t[32] - edge_t[31] == 7*TDIV, "R6 second gap", 32'(edge_t[32] - edge_t[31]), 7*TDIV);
    chk(stream_errs(32'h3C, 8, 1'b0, 3) == 0, "R3 burst stream", 32'(stream_errs(32'h3C, 8, 1'b0, 3)), 0);
    chk(ss_hi > 0, "R8 ss released in gap", 32'(ss_hi), 1);

    // R6 burst with gap 0
    words_m1 = 2'd1; gap_sel = 4'd0;
    @(negedge clk);
    run_xfer(-1);
    chk(edge_t[16] - edge_t[15] == TDIV, "R6 half-period gap", 32'(edge_t[16] - edge_t[15]), TDIV);
    chk(ss_hi == 0, "R8 ss held across zero gap", 32'(ss_hi), 0);
    chk(n_dones == 2, "R6 two words", 32'(n_dones), 2);

    // R9 start while busy ignored
    words_m1 = '0; gap_sel = 4'd3;
    @(negedge clk);
    run_xfer(10);
    chk(n_edges == 16 && n_dones == 1, "R9 restart ignored", 32'(n_edges), 16);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R9 no second transfer", 32'(busy), 0);

    // R8 manual slave select
    auto_ss = 0; ss_manual = 1;
    @(negedge clk);
    chk(ss_n == 0, "R8 manual select while idle", 32'(ss_n), 0);
    ss_manual = 0;
    run_xfer(-1);
    chk(ss_lo == 0, "R8 manual deselect while busy", 32'(ss_lo), 0);
    auto_ss = 1;

    // R9 abort
    if_clr = 1;
    @(negedge clk);
    if_clr = 0;
    cpol = 1; len_code = 5'd0;
    repeat (2) @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (30) @(negedge clk);
    abort = 1;
    @(negedge clk);
    abort = 0;
    chk(busy == 0, "R9 abort clears busy", 32'(busy), 0);
    chk(sclk == 1, "R9 R2 abort returns sclk idle", 32'(sclk), 1);
    begin
      int dseen;
      dseen = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (done) dseen++;
      end
      chk(dseen == 0, "R9 no done after abort", 32'(dseen), 0);
      chk(flag == 0, "R10 flag untouched by abort", 32'(flag), 0);
    end

    finish_run();
  end
endmodule